// File: doc/BRIEF.md
# Programmable Filtered Event Counter

This block is one programmable performance-monitoring counter. Each cycle it picks one group of raw sub-event lines by an 8-bit event code, masks that group with an 8-bit unit mask, and adds up the lines still asserted. If the sibling option is set, it also adds a count supplied by the other logical processor. That per-cycle count then passes through three filters in turn before it reaches a 40-bit accumulator. The first is a threshold comparator whose sense can be inverted. The second is an optional rising-edge detector. The third is a privilege gate.

Software sets the selection and qualifiers through a small register interface. The same interface reads and writes the count and clears a sticky overflow flag, which drives an interrupt output.

Top module: `pec_counter`

## Requirements
- R1: The event code picks one of four 8-line groups of `ev_lines_i`: code 0x03 selects bits [7:0], 0x04 selects [15:8], 0x05 selects [23:16] and 0x80 selects [31:24]. The per-cycle count is the number of lines in that group that are set in the unit mask and asserted. Any other code gives a count of zero.
- R2: With a threshold of zero, the counter adds the whole per-cycle count each cycle and the invert bit has no effect.
- R3: With a non-zero threshold, the counter adds exactly one in each cycle whose count is at least the threshold, and nothing otherwise.
- R4: With a non-zero threshold and invert set, the counter adds one in each cycle whose count is below the threshold.
- R5: With edge mode set, the counter adds one only in a cycle where the qualified condition is true and was false in the previous cycle. The condition is the threshold result, or "count non-zero" when the threshold is zero. The stored previous value resets to false.
- R6: The kernel bit permits counting at privilege level 0. The user bit permits counting at levels 1 to 3. When both bits are clear, all levels count.
- R7: With the sibling bit set, `sib_count_i` is added to the per-cycle count before the threshold.
- R8: Register addresses are 0 for configuration, 1 for count bits [31:0], 2 for count bits [39:32] and 3 for status (bit 0 = overflow). A software write to either count half replaces that half and suppresses the increment in the same cycle.
- R9: When an increment carries past all ones and interrupt-enable is set, the overflow flag is set. It stays set and drives `irq_o` until software writes 1 to status bit 0. With interrupt-enable clear, the count still wraps and the flag stays clear.
- R10: While the global enable is low, the count holds and the edge history is cleared, so an event that is still active when counting is re-enabled counts once more.
- R11: After reset, every register reads zero and `irq_o` is low.

Configuration word layout: [7:0] event code, [15:8] unit mask, [23:16] threshold, bit 24 user, bit 25 kernel, bit 26 edge, bit 27 sibling, bit 28 invert, bit 29 interrupt-enable, bit 30 global enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ev_lines_i | input | 32 | Raw sub-event lines, four groups of eight |
| sib_count_i | input | 4 | Event count from the sibling logical processor |
| priv_lvl_i | input | 2 | Current privilege level |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Overflow interrupt |

## Verification
Two functions can fall in the same cycle: a software write to the count and a filtered increment. The bench provokes this by holding five event lines active while it writes one count half. It then reads back exactly the written value, and in the following cycle that value plus five.

A second collision is an increment that wraps the 40-bit count. The bench preloads the count with all ones minus one and pulses three events for a single cycle. It then checks the low word, the high byte, the status flag and the interrupt line, and confirms the flag survives until it is cleared.

// File: rtl/pec_pkg.sv
package pec_pkg;
    parameter int CNT_W   = 40;
    parameter int DATA_W  = 32;
    parameter int LINES   = 8;
    parameter int NUM_GRP = 4;
    parameter int SIB_W   = 4;

    localparam int HI_W  = CNT_W - DATA_W;
    localparam int EVC_W = $clog2(LINES + (1 << SIB_W));

    // Event code served by each line group.
    function automatic logic [7:0] grp_code(input int g);
        case (g)
            0:       return 8'h03;
            1:       return 8'h04;
            2:       return 8'h05;
            default: return 8'h80;
        endcase
    endfunction

    typedef struct packed {
        logic       en;
        logic       irq_en;
        logic       inv;
        logic       any;
        logic       edge_en;
        logic       os;
        logic       usr;
        logic [7:0] cmask;
        logic [7:0] umask;
        logic [7:0] code;
    } cfg_t;

    typedef enum logic [1:0] {
        REG_CFG  = 2'd0,
        REG_LO   = 2'd1,
        REG_HI   = 2'd2,
        REG_STAT = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/pec_event_mux.sv
module pec_event_mux
    import pec_pkg::*;
#(
    parameter int N_LINES = LINES,
    parameter int N_GRP   = NUM_GRP,
    parameter int S_W     = SIB_W,
    parameter int C_W     = EVC_W
) (
    input  logic [N_GRP*N_LINES-1:0] lines_i,
    input  logic [7:0]               code_i,
    input  logic [N_LINES-1:0]       umask_i,
    input  logic                     any_i,
    input  logic [S_W-1:0]           sib_i,
    output logic [C_W-1:0]           evc_o
);
    logic [N_GRP-1:0]   hit;
    logic [N_LINES-1:0] sel;
    logic [N_LINES-1:0] masked;
    logic [C_W-1:0]     pop;

    for (genvar g = 0; g < N_GRP; g++) begin : g_hit
        assign hit[g] = (code_i == grp_code(g));
    end

    always_comb begin
        sel = '0;
        for (int g = 0; g < N_GRP; g++) begin
            if (hit[g]) sel = lines_i[g*N_LINES +: N_LINES];
        end
        masked = sel & umask_i;
        pop = '0;
        for (int i = 0; i < N_LINES; i++) begin
            pop = pop + C_W'(masked[i]);
        end
        evc_o = pop + (any_i ? C_W'(sib_i) : '0);
    end
endmodule

// File: rtl/pec_qualifier.sv
module pec_qualifier
    import pec_pkg::*;
#(
    parameter int C_W = EVC_W
) (
    input  logic [C_W-1:0] evc_i,
    input  logic [7:0]     cmask_i,
    input  logic           inv_i,
    input  logic           edge_i,
    input  logic           prev_i,
    output logic           cond_o,
    output logic [C_W-1:0] inc_o
);
    logic thr_on;
    logic at_least;

    always_comb begin
        thr_on   = (cmask_i != 8'd0);
        at_least = ({{(8 > C_W ? 8 - C_W : 0){1'b0}}, evc_i} >= cmask_i);
        cond_o   = thr_on ? (at_least ^ inv_i) : (evc_i != '0);
        if (edge_i)      inc_o = C_W'(cond_o && !prev_i);
        else if (thr_on) inc_o = C_W'(cond_o);
        else             inc_o = evc_i;
    end
endmodule

// File: rtl/pec_priv_gate.sv
module pec_priv_gate (
    input  logic [1:0] priv_i,
    input  logic       os_i,
    input  logic       usr_i,
    output logic       pass_o
);
    logic none_set;

    always_comb begin
        none_set = !os_i && !usr_i;
        pass_o   = none_set || ((priv_i == 2'd0) ? os_i : usr_i);
    end
endmodule

// File: rtl/pec_counter.sv
module pec_counter
    import pec_pkg::*;
(
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [NUM_GRP*LINES-1:0] ev_lines_i,
    input  logic [SIB_W-1:0]         sib_count_i,
    input  logic [1:0]               priv_lvl_i,
    input  logic                     reg_we_i,
    input  logic [1:0]               reg_addr_i,
    input  logic [DATA_W-1:0]        reg_wdata_i,
    output logic [DATA_W-1:0]        reg_rdata_o,
    output logic                     irq_o
);
    typedef struct packed {
        cfg_t             cfg;
        logic [CNT_W-1:0] cnt;
        logic             prev;
        logic             ovf;
    } state_t;

    state_t st_d, st_q;

    logic [EVC_W-1:0] evc;
    logic [EVC_W-1:0] inc;
    logic             cond;
    logic             priv_ok;
    logic             cnt_wr;
    logic [CNT_W:0]   sum;

    cfg_t             cfg_view;
    logic [CNT_W-1:0] cnt_view;
    logic             ovf_view;

    pec_event_mux u_mux (
        .lines_i (ev_lines_i),
        .code_i  (st_q.cfg.code),
        .umask_i (st_q.cfg.umask[LINES-1:0]),
        .any_i   (st_q.cfg.any),
        .sib_i   (sib_count_i),
        .evc_o   (evc)
    );

    pec_qualifier u_qual (
        .evc_i   (evc),
        .cmask_i (st_q.cfg.cmask),
        .inv_i   (st_q.cfg.inv),
        .edge_i  (st_q.cfg.edge_en),
        .prev_i  (st_q.prev),
        .cond_o  (cond),
        .inc_o   (inc)
    );

    pec_priv_gate u_priv (
        .priv_i (priv_lvl_i),
        .os_i   (st_q.cfg.os),
        .usr_i  (st_q.cfg.usr),
        .pass_o (priv_ok)
    );

    always_comb begin
        st_d   = st_q;
        cnt_wr = reg_we_i && ((reg_addr_i == REG_LO) || (reg_addr_i == REG_HI));
        sum    = {1'b0, st_q.cnt} + (CNT_W + 1)'(inc);

        st_d.prev = st_q.cfg.en ? cond : 1'b0;

        if (reg_we_i) begin
            case (reg_addr_e'(reg_addr_i))
                REG_CFG:  st_d.cfg = cfg_t'(reg_wdata_i[$bits(cfg_t)-1:0]);
                REG_LO:   st_d.cnt = {st_q.cnt[CNT_W-1:DATA_W], reg_wdata_i};
                REG_HI:   st_d.cnt = {reg_wdata_i[HI_W-1:0], st_q.cnt[DATA_W-1:0]};
                REG_STAT: if (reg_wdata_i[0]) st_d.ovf = 1'b0;
                default:  ;
            endcase
        end

        if (st_q.cfg.en && priv_ok && !cnt_wr) begin
            st_d.cnt = sum[CNT_W-1:0];
            if (sum[CNT_W] && st_q.cfg.irq_en) st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        case (reg_addr_e'(reg_addr_i))
            REG_CFG:  reg_rdata_o = DATA_W'(st_q.cfg);
            REG_LO:   reg_rdata_o = st_q.cnt[DATA_W-1:0];
            REG_HI:   reg_rdata_o = DATA_W'(st_q.cnt[CNT_W-1:DATA_W]);
            default:  reg_rdata_o = DATA_W'(st_q.ovf);
        endcase
    end

    assign irq_o    = st_q.ovf;
    assign cfg_view = st_q.cfg;
    assign cnt_view = st_q.cnt;
    assign ovf_view = st_q.ovf;
endmodule

// File: rtl/pec_counter_chk.sv
module pec_counter_chk
    import pec_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              we,
    input logic [1:0]        addr,
    input logic [DATA_W-1:0] wdata,
    input logic [1:0]        priv,
    input cfg_t              cfg,
    input logic [CNT_W-1:0]  cnt,
    input logic              ovf
);
    logic cnt_wr;
    logic clr_wr;
    assign cnt_wr = we && ((addr == REG_LO) || (addr == REG_HI));
    assign clr_wr = we && (addr == REG_STAT) && wdata[0];

    AST_LO_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we && addr == REG_LO) |=> (cnt[DATA_W-1:0] == $past(wdata))); // R8

    AST_FROZEN_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cfg.en && !cnt_wr) |=> $stable(cnt)); // R10

    AST_PRIV_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg.os && !cfg.usr && priv != 2'd0 && !cnt_wr) |=> $stable(cnt)); // R6

    AST_EDGE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg.en && cfg.edge_en && !cnt_wr && cnt != '1)
        |=> ((cnt - $past(cnt)) <= CNT_W'(1))); // R5

    AST_THRESH_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg.en && cfg.cmask != 8'd0 && !cnt_wr && cnt != '1)
        |=> ((cnt - $past(cnt)) <= CNT_W'(1))); // R3

    AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf && !clr_wr) |=> ovf); // R9

    AST_NO_OVF_WITHOUT_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ovf && !cfg.irq_en) |=> !ovf); // R9
endmodule

bind pec_counter pec_counter_chk u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we     (reg_we_i),
    .addr   (reg_addr_i),
    .wdata  (reg_wdata_i),
    .priv   (priv_lvl_i),
    .cfg    (cfg_view),
    .cnt    (cnt_view),
    .ovf    (ovf_view)
);

// File: tb/pec_counter_tb.sv
`timescale 1ns/100ps
module pec_counter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lines = '0;
    logic [3:0]  sib = '0;
    logic [1:0]  pl = '0;
    logic        we = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int nchk = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    pec_counter u_dut (
        .clk_i (clk), .rst_ni (rst_n), .ev_lines_i (lines),
        .sib_count_i (sib), .priv_lvl_i (pl), .reg_we_i (we),
        .reg_addr_i (addr), .reg_wdata_i (wdata), .reg_rdata_o (rdata),
        .irq_o (irq)
    );

    // flags: 0 user, 1 kernel, 2 edge, 3 sibling, 4 invert, 5 irq enable, 6 enable
    typedef struct packed {
        logic [7:0]  code;
        logic [7:0]  umask;
        logic [7:0]  cmask;
        logic [7:0]  flags;
        logic [31:0] stim;
        logic [3:0]  sib;
        logic [1:0]  pl;
        logic [7:0]  exp;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{8'h05, 8'h01, 8'h00, 8'h03, 32'h0001_0000, 4'd0, 2'd0, 8'd1}, // R1 data-side group
        '{8'h05, 8'h02, 8'h00, 8'h03, 32'h0001_0000, 4'd0, 2'd0, 8'd0}, // R1 mask misses
        '{8'h03, 8'hFF, 8'h00, 8'h03, 32'h0000_00B5, 4'd0, 2'd3, 8'd5}, // R1 popcount
        '{8'h80, 8'h0F, 8'h00, 8'h03, 32'hFF00_0000, 4'd0, 2'd1, 8'd4}, // R1 top group
        '{8'h22, 8'hFF, 8'h00, 8'h03, 32'hFFFF_FFFF, 4'd0, 2'd0, 8'd0}, // R1 unknown code
        '{8'h04, 8'hFF, 8'h00, 8'h13, 32'h0000_0700, 4'd0, 2'd0, 8'd3}, // R2 invert ignored
        '{8'h04, 8'hFF, 8'h03, 8'h03, 32'h0000_0700, 4'd0, 2'd0, 8'd1}, // R3 equal
        '{8'h04, 8'hFF, 8'h04, 8'h03, 32'h0000_0700, 4'd0, 2'd0, 8'd0}, // R3 below
        '{8'h04, 8'hFF, 8'h04, 8'h13, 32'h0000_0700, 4'd0, 2'd0, 8'd1}, // R4 below
        '{8'h04, 8'hFF, 8'h03, 8'h13, 32'h0000_0700, 4'd0, 2'd0, 8'd0}, // R4 equal
        '{8'h04, 8'h01, 8'h00, 8'h0B, 32'h0000_0100, 4'd6, 2'd0, 8'd7}, // R7 sibling added
        '{8'h04, 8'h01, 8'h00, 8'h03, 32'h0000_0100, 4'd6, 2'd0, 8'd1}, // R7 sibling off
        '{8'h03, 8'hFF, 8'h00, 8'h02, 32'h0000_00FF, 4'd0, 2'd2, 8'd0}, // R6 kernel only, level 2
        '{8'h03, 8'hFF, 8'h00, 8'h02, 32'h0000_00FF, 4'd0, 2'd0, 8'd8}, // R6 kernel only, level 0
        '{8'h03, 8'hFF, 8'h00, 8'h01, 32'h0000_00FF, 4'd0, 2'd0, 8'd0}, // R6 user only, level 0
        '{8'h03, 8'hFF, 8'h00, 8'h01, 32'h0000_00FF, 4'd0, 2'd3, 8'd8}, // R6 user only, level 3
        '{8'h03, 8'hFF, 8'h00, 8'h00, 32'h0000_00FF, 4'd0, 2'd2, 8'd8}, // R6 neither set
        '{8'h03, 8'h01, 8'h00, 8'h07, 32'h0000_0001, 4'd0, 2'd0, 8'd1}, // R5 edge, no threshold
        '{8'h03, 8'hFF, 8'h02, 8'h07, 32'h0000_0007, 4'd0, 2'd0, 8'd1}  // R5 edge, threshold
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    function automatic logic [31:0] mkcfg(input logic [7:0] f, input logic [7:0] cm,
                                          input logic [7:0] um, input logic [7:0] cd);
        return {f, cm, um, cd};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check($sformatf("R11 reg %0d", a), 64'(v), 64'd0);
        end
        check("R11 irq", 64'(irq), 64'd0);

        // Table walk: R1 R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            lines = VEC[i].stim; sib = VEC[i].sib; pl = VEC[i].pl;
            wr(2'd0, mkcfg(VEC[i].flags & 8'hBF, VEC[i].cmask, VEC[i].umask, VEC[i].code));
            wr(2'd1, 32'd0);
            wr(2'd0, mkcfg(VEC[i].flags | 8'h40, VEC[i].cmask, VEC[i].umask, VEC[i].code));
            @(negedge clk);
            rd(2'd1, v);
            check($sformatf("vector %0d", i), 64'(v), 64'(VEC[i].exp));
        end

        // R5 long duration counts occurrences
        lines = '0; sib = '0; pl = '0;
        wr(2'd0, mkcfg(8'h07, 8'h00, 8'h01, 8'h03));
        wr(2'd1, 32'd0);
        wr(2'd0, mkcfg(8'h47, 8'h00, 8'h01, 8'h03));
        lines = 32'h1;
        repeat (5) @(negedge clk);
        lines = '0;
        @(negedge clk);
        lines = 32'h1;
        repeat (3) @(negedge clk);
        rd(2'd1, v);
        check("R5 two occurrences", 64'(v), 64'd2);

        // R10 freeze and history clear (condition still held)
        wr(2'd0, mkcfg(8'h07, 8'h00, 8'h01, 8'h03));
        repeat (3) @(negedge clk);
        rd(2'd1, v);
        check("R10 frozen", 64'(v), 64'd2);
        wr(2'd0, mkcfg(8'h47, 8'h00, 8'h01, 8'h03));
        @(negedge clk);
        rd(2'd1, v);
        check("R10 history cleared", 64'(v), 64'd3);
        wr(2'd0, mkcfg(8'h03, 8'h00, 8'hFF, 8'h03));
        lines = 32'hFF;
        repeat (2) @(negedge clk);
        rd(2'd1, v);
        check("R10 frozen count mode", 64'(v), 64'd3);

        // R8 write beats increment
        lines = 32'h1F;
        wr(2'd0, mkcfg(8'h43, 8'h00, 8'hFF, 8'h03));
        wr(2'd1, 32'h100);
        rd(2'd1, v);
        check("R8 lo write wins", 64'(v), 64'h100);
        @(negedge clk);
        rd(2'd1, v);
        check("R8 count resumes", 64'(v), 64'h105);
        wr(2'd2, 32'hAB);
        rd(2'd2, v);
        check("R8 hi written", 64'(v), 64'hAB);
        rd(2'd1, v);
        check("R8 hi write blocks increment", 64'(v), 64'h105);

        // R9 wrap with interrupt enable
        lines = '0;
        wr(2'd0, mkcfg(8'h63, 8'h00, 8'hFF, 8'h03));
        wr(2'd2, 32'hFF);
        wr(2'd1, 32'hFFFF_FFFE);
        lines = 32'h7;
        @(negedge clk);
        lines = '0;
        rd(2'd1, v);
        check("R9 wrapped lo", 64'(v), 64'd1);
        rd(2'd2, v);
        check("R9 wrapped hi", 64'(v), 64'd0);
        rd(2'd3, v);
        check("R9 status set", 64'(v), 64'd1);
        check("R9 irq raised", 64'(irq), 64'd1);
        repeat (2) @(negedge clk);
        check("R9 irq sticky", 64'(irq), 64'd1);
        wr(2'd3, 32'h1);
        check("R9 irq cleared", 64'(irq), 64'd0);

        // R9 wrap without interrupt enable
        wr(2'd0, mkcfg(8'h43, 8'h00, 8'hFF, 8'h03));
        wr(2'd2, 32'hFF);
        wr(2'd1, 32'hFFFF_FFFE);
        lines = 32'h7;
        @(negedge clk);
        lines = '0;
        rd(2'd1, v);
        check("R9 wrap no ie lo", 64'(v), 64'd1);
        check("R9 no irq without ie", 64'(irq), 64'd0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule